// File: doc/BRIEF.md
# Six-Pulse Thyristor Firing Sequencer

This block times the six gate pulses of a 6-pulse controlled rectifier bridge. It watches a sampled phase-to-phase synchronising voltage, one sample per clock, in two's complement. When that voltage turns from negative to non-negative, the block treats the moment as the angular reference of the cycle. It waits for the commanded firing angle and then raises S1. S2 to S6 follow at equal spacing of one sixth of the fundamental period.

Both the firing delay and the pulse spacing come from a measured period input, given in clock ticks. They are not taken from a fixed nominal frequency, so the firing pattern follows the supply as its frequency drifts. The firing angle is a fraction of one cycle. After reset, and each time the enable is raised again, the block lets a hold-off interval pass before it acts on any reference crossing. This keeps the bridge from firing on an unsettled synchronising signal.

Top module: `bridge_fire_seq`

## Requirements
- R1: A reference crossing is a clock where the previous sample of `v_sync` had its sign bit (bit VW-1) set and the current sample has it clear. No other sample pair starts a firing sequence.
- R2: For a crossing accepted at clock edge E, S1 (`gate[0]`) rises at edge E+D+1. Here D = floor(`alpha` × `period` / 2^AW), with `alpha` and `period` taken at edge E. An `alpha` of zero therefore fires one tick after the crossing.
- R3: S(k+1) (`gate[k]`) rises exactly `step` ticks after S(k), for k = 1..5. Here `step` = floor(`period` / 6), using the period taken at the accepted crossing, with a minimum of 1.
- R4: Changes on `alpha` or `period` between two accepted crossings do not alter the sequence already started. They take effect at the next accepted crossing.
- R5: Each rise of a gate line keeps that line high for exactly PULSE_TICKS clocks, unless enable is dropped.
- R6: While `en` is low, all gates are low and any sequence is abandoned. Crossings are ignored until `en` has been high for HOLD_TICKS clock edges, counted again from zero at every rise of `en` and after reset.
- R7: A candidate crossing that comes fewer than floor(P/2) ticks after the previous accepted crossing is ignored. P is the period taken at that previous crossing.
- R8: An accepted crossing that arrives before S6 has been issued restarts the sequence at S1. Pulses not yet issued are dropped.
- R9: While `rst` is high, and on the clock after, all six gate lines are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; rising restarts hold-off, low clears all gates |
| v_sync | input | VW | Signed phase-to-phase synchronising voltage sample |
| period | input | PW | Measured fundamental period in clock ticks |
| alpha | input | AW | Firing angle as alpha/2^AW of one cycle |
| gate | output | 6 | Gate pulses, bit k-1 drives thyristor Sk |

## Verification
A square synchronising wave with a modest firing angle shows the basic delay and the equal spacing. Running it first from enable also shows that nothing fires during the hold-off. A zero angle tests the shortest delay. A long angle pushes the later pulses past the next crossing, which separates a correct restart from a sequence that finishes anyway. Other patterns test further rules. Moving `alpha` and `period` in the middle of a cycle shows whether the values are latched at the crossing. A one-sample dip just after a crossing checks the half-period qualifier. A short period with a small step shows that the divide-by-six is exact. Dropping enable in mid-sequence tests that the gates clear and that the hold-off starts again.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

    localparam int BFS_PHASES = 6;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } seq_state_e;

    // shift used with the constant reciprocal of six
    function automatic int div6_shift(input int pw);
        return pw + 3;
    endfunction

endpackage

// File: rtl/bfs_zc_gate.sv
module bfs_zc_gate #(
    parameter int VW         = 16,
    parameter int PW         = 20,
    parameter int HOLD_TICKS = 2500000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic signed [VW-1:0] v_sync,
    input  logic [PW-1:0]        period,
    output logic                 accept
);
    localparam int HW = $clog2(HOLD_TICKS + 1);
    localparam logic [HW-1:0] HOLD_END  = HW'(HOLD_TICKS);
    localparam logic [PW-1:0] SINCE_MAX = '1;

    logic [HW-1:0] ho_q;
    logic          prev_neg_q;
    logic          have_q;
    logic [PW-1:0] since_q;
    logic [PW-1:0] half_q;
    logic          cur_neg;
    logic          ho_done;
    logic          spaced;

    assign cur_neg = v_sync[VW-1];
    assign ho_done = (ho_q == HOLD_END);
    assign spaced  = !have_q || (since_q >= half_q);
    assign accept  = en && ho_done && prev_neg_q && !cur_neg && spaced;

    always_ff @(posedge clk) begin
        if (rst) prev_neg_q <= 1'b0;
        else     prev_neg_q <= cur_neg;
    end

    always_ff @(posedge clk) begin
        if (rst || !en)    ho_q <= '0;
        else if (!ho_done) ho_q <= ho_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            since_q <= '0;
            have_q  <= 1'b0;
            half_q  <= '0;
        end else if (accept) begin
            since_q <= PW'(1);
            have_q  <= 1'b1;
            half_q  <= period >> 1;
        end else if (since_q != SINCE_MAX) begin
            since_q <= since_q + 1'b1;
        end
    end

    // R1: acceptance only follows a negative sample
    a_r1_after_negative: assert property (@(posedge clk) disable iff (rst)
        accept |-> $past(v_sync[VW-1]));

    // R6: hold-off restarts on a rising enable
    a_r6_holdoff_restart: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |-> !accept);

endmodule

// File: rtl/bfs_seq.sv
module bfs_seq
    import bfs_pkg::*;
#(
    parameter int PW  = 20,
    parameter int AW  = 12,
    parameter int NPH = BFS_PHASES
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic           accept,
    input  logic [PW-1:0]  period,
    input  logic [AW-1:0]  alpha,
    output logic [NPH-1:0] fire
);
    localparam int RSH = div6_shift(PW);
    localparam int IW  = $clog2(NPH);
    localparam logic [PW:0]   RECIP = (PW+1)'((64'd1 << RSH) / 6 + 1);
    localparam logic [IW-1:0] LAST  = IW'(NPH - 1);

    logic [2*PW:0]    div_prod;
    logic [PW-1:0]    step_raw;
    logic [PW-1:0]    step_eff;
    logic [PW+AW-1:0] dly_prod;
    logic [PW-1:0]    dly;

    seq_state_e    st_q;
    logic [IW-1:0] idx_q;
    logic [PW-1:0] cnt_q;
    logic [PW-1:0] step_q;
    logic          due;

    assign div_prod = (2*PW+1)'(period) * (2*PW+1)'(RECIP);
    assign step_raw = PW'(div_prod >> RSH);
    assign step_eff = (step_raw == '0) ? PW'(1) : step_raw;
    assign dly_prod = (PW+AW)'(period) * (PW+AW)'(alpha);
    assign dly      = dly_prod[PW+AW-1:AW];
    assign due      = (st_q == SQ_RUN) && (cnt_q == '0);

    always_comb begin
        fire = '0;
        if (due) fire[idx_q] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st_q   <= SQ_IDLE;
            idx_q  <= '0;
            cnt_q  <= '0;
            step_q <= '0;
        end else if (accept) begin
            st_q   <= SQ_RUN;
            idx_q  <= '0;
            cnt_q  <= dly;
            step_q <= step_eff;
        end else if (due) begin
            if (idx_q == LAST) begin
                st_q <= SQ_IDLE;
            end else begin
                idx_q <= idx_q + 1'b1;
                cnt_q <= step_q - 1'b1;
            end
        end else if (st_q == SQ_RUN) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R3: at most one line fires per tick
    a_r3_single_fire: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fire));

    // R8: an accepted crossing restarts at the first line
    a_r8_restart_s1: assert property (@(posedge clk) disable iff (rst)
        (accept && en) |=> (st_q == SQ_RUN && idx_q == '0));

endmodule

// File: rtl/bfs_stretch.sv
module bfs_stretch #(
    parameter int WIDTH = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic fire,
    output logic gate
);
    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LOADV = CW'(WIDTH - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            gate  <= 1'b0;
            cnt_q <= '0;
        end else if (fire) begin
            gate  <= 1'b1;
            cnt_q <= LOADV;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else begin
            gate <= 1'b0;
        end
    end

    // R5: a fire strobe raises the line on the next tick
    a_r5_fire_raises: assert property (@(posedge clk) disable iff (rst)
        (!clr && fire) |=> gate);

    // R6: clearing forces the line low
    a_r6_clear_low: assert property (@(posedge clk) disable iff (rst)
        clr |=> !gate);

endmodule

// File: rtl/bridge_fire_seq.sv
module bridge_fire_seq
    import bfs_pkg::*;
#(
    parameter int VW          = 16,
    parameter int PW          = 20,
    parameter int AW          = 12,
    parameter int PULSE_TICKS = 250,
    parameter int HOLD_TICKS  = 2500000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic signed [VW-1:0] v_sync,
    input  logic [PW-1:0]        period,
    input  logic [AW-1:0]        alpha,
    output logic [5:0]           gate
);
    logic                  accept;
    logic [BFS_PHASES-1:0] fire;

    bfs_zc_gate #(.VW(VW), .PW(PW), .HOLD_TICKS(HOLD_TICKS)) u_zc (
        .clk(clk), .rst(rst), .en(en), .v_sync(v_sync),
        .period(period), .accept(accept)
    );

    bfs_seq #(.PW(PW), .AW(AW), .NPH(BFS_PHASES)) u_seq (
        .clk(clk), .rst(rst), .en(en), .accept(accept),
        .period(period), .alpha(alpha), .fire(fire)
    );

    for (genvar k = 0; k < BFS_PHASES; k++) begin : g_line
        bfs_stretch #(.WIDTH(PULSE_TICKS)) u_str (
            .clk(clk), .rst(rst), .clr(!en),
            .fire(fire[k]), .gate(gate[k])
        );
    end

    // R9: reset leaves every line low
    a_r9_reset_quiet: assert property (@(posedge clk)
        rst |=> (gate == '0));

endmodule

// File: tb/test_bridge_fire_seq.sv
module test_bridge_fire_seq;
    localparam int VW = 12;
    localparam int PW = 16;
    localparam int AW = 8;
    localparam int PT = 4;
    localparam int HT = 200;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 en;
    logic signed [VW-1:0] v_sync;
    logic [PW-1:0]        period;
    logic [AW-1:0]        alpha;
    logic [5:0]           gate;

    always #2 clk = ~clk;

    bridge_fire_seq #(.VW(VW), .PW(PW), .AW(AW), .PULSE_TICKS(PT), .HOLD_TICKS(HT))
        i_bridge_fire_seq (.clk(clk), .rst(rst), .en(en), .v_sync(v_sync),
                           .period(period), .alpha(alpha), .gate(gate));

    int checks = 0;
    int errors = 0;
    longint n = 0;
    int ho = 0;
    bit prev_neg = 0;
    bit have = 0;
    longint since = 0;
    longint half = 0;
    longint pend[6];
    longint lastr[6];
    int model_rises = 0;
    int dut_rises = 0;
    logic [5:0] prev_gate = '0;
    int sig_per = 240;
    int ph = 0;
    bit glitch = 0;

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    task automatic model_edge();
        bit cand;
        bit acc;
        longint d;
        longint st;
        n++;
        if (rst || !en) begin
            for (int k = 0; k < 6; k++) begin pend[k] = -1; lastr[k] = -1; end
            ho = 0; have = 0; since = 0; half = 0;
            prev_neg = rst ? 1'b0 : (v_sync < 0);
            return;
        end
        cand = prev_neg && (v_sync >= 0);
        acc = (ho == HT) && cand && (!have || since >= half);
        prev_neg = (v_sync < 0);
        if (ho < HT) ho++;
        for (int k = 0; k < 6; k++) begin
            if (pend[k] == n) begin lastr[k] = n; pend[k] = -1; model_rises++; end
        end
        if (acc) begin
            since = 1; have = 1; half = period / 2;
            d = (longint'(alpha) * longint'(period)) >> AW;
            st = period / 6;
            if (st == 0) st = 1;
            for (int k = 0; k < 6; k++) pend[k] = n + d + 1 + k * st;
        end else if (since < 65535) begin
            since++;
        end
    endtask

    task automatic compare(string tg);
        logic [5:0] exp;
        for (int k = 0; k < 6; k++)
            exp[k] = (lastr[k] >= 0) && (n >= lastr[k]) && (n < lastr[k] + PT);
        for (int k = 0; k < 6; k++) if (gate[k] && !prev_gate[k]) dut_rises++;
        prev_gate = gate;
        checks++;
        if (gate !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d gate=%b expected=%b", tg, n, gate, exp);
        end
    endtask

    task automatic drive_next();
        ph = (ph + 1) % sig_per;
        v_sync = (ph < sig_per / 2) ? VW'(100) : -VW'(100);
        if (glitch && ph == 2) v_sync = -VW'(40);
    endtask

    task automatic tick(string tg);
        @(posedge clk);
        #1;
        model_edge();
        compare(tg);
        drive_next();
    endtask

    task automatic run(string tg, int cycles, bit wobble);
        model_rises = 0;
        dut_rises = 0;
        for (int c = 0; c < cycles; c++) begin
            if (wobble && (c % 37) == 5) begin
                alpha  = AW'(8 + (c * 7) % 32);
                period = PW'(236 + (c % 9));
            end
            tick(tg);
        end
        checks++;
        if (dut_rises != model_rises) begin
            errors++;
            $display("FAIL %s pulse count actual=%0d expected=%0d", tg, dut_rises, model_rises);
        end
    endtask

    initial begin
        for (int k = 0; k < 6; k++) begin pend[k] = -1; lastr[k] = -1; end
        rst = 1'b1; en = 1'b0; v_sync = -VW'(100);
        period = PW'(240); alpha = AW'(32);
        for (int c = 0; c < 4; c++) tick("R9 reset");
        rst = 1'b0;
        tick("R9 reset");
        // hold-off, basic delay, equal spacing, pulse width
        en = 1'b1;
        run("R1 R2 R3 R5 R6 basic", 1200, 1'b0);
        // mid-cycle command changes
        run("R4 latch", 1500, 1'b1);
        // zero firing angle, longer period
        sig_per = 300; period = PW'(300); alpha = AW'(0);
        run("R2 zero angle", 900, 1'b0);
        // chatter just after a crossing
        glitch = 1'b1; alpha = AW'(20);
        run("R7 chatter", 900, 1'b0);
        glitch = 1'b0;
        // late angle pushes pulses past the next crossing
        sig_per = 240; period = PW'(240); alpha = AW'(200);
        run("R8 restart", 900, 1'b0);
        // enable drop mid-sequence, then hold-off again
        alpha = AW'(40);
        run("R6 enabled", 350, 1'b0);
        en = 1'b0;
        run("R6 disabled", 50, 1'b0);
        en = 1'b1;
        run("R6 reenabled", 800, 1'b0);
        // short period, small step
        sig_per = 60; period = PW'(60); alpha = AW'(16);
        run("R3 short step", 600, 1'b0);
        summary();
        $finish;
    end
endmodule